// File: doc/BRIEF.md
# Video Memory Byte Access Port

This block gives a CPU byte-wide access to a video memory organised as 16-bit words. The CPU sees a window of 64 byte registers on a simple synchronous bus. It loads a 16-bit word address through two byte registers, then moves data through separate low-byte and high-byte data ports. After each access to the selected trigger byte, the word address advances by a programmable step. Reads and writes both cause this step, so a CPU can walk rows or columns of a tile map with plain byte accesses.

A control register sets two things: the step size, which is 1, 32 or 128 words, and which data byte causes the step. Each word has a low lane and a high lane, and each lane is kept in its own byte bank. The high byte sits at the even byte location and the low byte at the odd one. A data write also leaves a copy of its byte in a read-only return register for that lane. Data-port reads return the memory byte one clock after the strobe. The memory index width is a parameter, `WORD_AW`. A full-size memory uses 15 bits. The default is smaller, so word addresses that differ only above the index width map to the same word.

Top module: `vram_port`

## Requirements
- R1: The 16-bit word address is built from a low-byte register (offset 0x01) and a high-byte register (offset 0x02). Either byte can be written alone and in any order, and both read back the current address.
- R2: Control bits [1:0] (offset 0x00) choose the step: 00 gives 1, 01 gives 32, and both 10 and 11 give 128.
- R3: When control bit 7 is 0, an access to the low data port (offset 0x03) advances the address and an access to the high data port (offset 0x04) leaves it unchanged. When bit 7 is 1, the roles of the two ports are swapped.
- R4: Reads of the data ports follow the same step and trigger rules as writes.
- R5: A word is indexed by the low `WORD_AW` bits of the word address. The high data port reaches the even byte location (2 × index) and the low data port reaches the odd location (2 × index + 1). A data-port read returns the byte last written to that lane of that word, so addresses that differ only above the index width reach the same word.
- R6: The window covers 64 byte registers starting at `WIN_BASE`. A read outside the window returns 0xFF. A write outside the window changes nothing.
- R7: The return registers (low at offset 0x08, high at offset 0x09) are read-only, and CPU writes to them are ignored. A data-port write copies its byte into the return register of the same lane.
- R8: The word address wraps modulo 2^16 when a step carries past 0xFFFF.
- R9: Reset clears the address, control and return registers to zero and leaves memory contents intact.
- R10: Read data is valid on the clock after the read strobe. The step caused by that read takes effect on the same edge, so a read on the very next cycle already sees the new address.
- R11: Any offset inside the window that has no register reads as 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one access per cycle |
| cpu_re | input | 1 | Read strobe, ignored while `cpu_we` is high |
| cpu_rdata | output | 8 | Read data, valid the clock after `cpu_re` |

## Verification
The hardest case to reach is one where a step and a read affect each other. A data-port read must return the memory byte at the old address, while the address register must already hold the stepped value on the next cycle. The stimulus drives back-to-back read strobes, first a data port and then an address byte, with no idle cycle between them. The aliasing case is reached by writing at an address with bits above the index width set, then reading back through an address with those bits cleared. The wrap case is reached by loading an address near 0xFFFF and stepping it by 32 and by 1.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WADDR_W = 2 * BYTE_W;
  localparam int unsigned OFS_W   = 6;

  // register offsets inside the window
  localparam logic [OFS_W-1:0] OFS_CTRL   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_ADR_LO = 6'h01;
  localparam logic [OFS_W-1:0] OFS_ADR_HI = 6'h02;
  localparam logic [OFS_W-1:0] OFS_DAT_LO = 6'h03;
  localparam logic [OFS_W-1:0] OFS_DAT_HI = 6'h04;
  localparam logic [OFS_W-1:0] OFS_RET_LO = 6'h08;
  localparam logic [OFS_W-1:0] OFS_RET_HI = 6'h09;

  localparam int unsigned CTRL_TRIG_BIT = 7;

  typedef struct packed {
    logic ctrl;
    logic adr_lo;
    logic adr_hi;
    logic dat_lo;
    logic dat_hi;
    logic ret_lo;
    logic ret_hi;
  } reg_hit_t;

  typedef enum logic [1:0] {
    RSRC_REG    = 2'd0,
    RSRC_MEM_LO = 2'd1,
    RSRC_MEM_HI = 2'd2
  } rsrc_e;

  function automatic logic [WADDR_W-1:0] step_amount(input logic [1:0] sel);
    logic [WADDR_W-1:0] s;
    case (sel)
      2'b00:   s = WADDR_W'(1);
      2'b01:   s = WADDR_W'(32);
      default: s = WADDR_W'(128);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vram_reg_decode.sv
module vram_reg_decode
  import vram_port_pkg::*;
#(
  parameter logic [WADDR_W-1:0] WIN_BASE = 16'h0400
) (
  input  logic [WADDR_W-1:0] addr,
  output logic               in_win,
  output reg_hit_t           hit
);

  logic [OFS_W-1:0] ofs;

  assign in_win = (addr[WADDR_W-1:OFS_W] == WIN_BASE[WADDR_W-1:OFS_W]);
  assign ofs    = addr[OFS_W-1:0];

  always_comb begin
    hit        = '0;
    hit.ctrl   = in_win && (ofs == OFS_CTRL);
    hit.adr_lo = in_win && (ofs == OFS_ADR_LO);
    hit.adr_hi = in_win && (ofs == OFS_ADR_HI);
    hit.dat_lo = in_win && (ofs == OFS_DAT_LO);
    hit.dat_hi = in_win && (ofs == OFS_DAT_HI);
    hit.ret_lo = in_win && (ofs == OFS_RET_LO);
    hit.ret_hi = in_win && (ofs == OFS_RET_HI);
  end

endmodule

// File: rtl/vram_addr_gen.sv
module vram_addr_gen
  import vram_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [BYTE_W-1:0]  ld_byte,
  input  logic               acc_lo,
  input  logic               acc_hi,
  input  logic               trig_on_hi,
  input  logic [1:0]         step_sel,
  output logic [WADDR_W-1:0] word_addr
);

  logic step_now;

  // only the selected lane advances the address
  assign step_now = trig_on_hi ? acc_hi : acc_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
    end else if (ld_lo) begin
      word_addr[BYTE_W-1:0] <= ld_byte;
    end else if (ld_hi) begin
      word_addr[WADDR_W-1:BYTE_W] <= ld_byte;
    end else if (step_now) begin
      word_addr <= word_addr + step_amount(step_sel);  // wraps at 2^16
    end
  end

endmodule

// File: rtl/vram_byte_bank.sv
module vram_byte_bank #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, synchronous read with enable: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h0400,
  parameter int unsigned WORD_AW  = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  input  logic        cpu_re,
  output logic [7:0]  cpu_rdata
);

  localparam int unsigned LANES = 2;  // lane 0 = low byte, lane 1 = high byte

  logic               in_win;
  reg_hit_t           hit;
  logic               rd_go;
  logic [BYTE_W-1:0]  ctrl_q;
  logic [BYTE_W-1:0]  ret_lo_q;
  logic [BYTE_W-1:0]  ret_hi_q;
  logic [WADDR_W-1:0] word_addr;
  logic [WORD_AW-1:0] mem_idx;
  logic [LANES-1:0]   lane_wr;
  logic [LANES-1:0]   lane_rd;
  logic [BYTE_W-1:0]  lane_q [LANES];
  logic [BYTE_W-1:0]  reg_rd_q;
  rsrc_e              rsrc_q;
  logic [BYTE_W-1:0]  reg_val;
  rsrc_e              rsrc_d;

  assign rd_go = cpu_re && !cpu_we;

  vram_reg_decode #(.WIN_BASE(WIN_BASE)) i_decode (
    .addr   (cpu_addr),
    .in_win (in_win),
    .hit    (hit)
  );

  assign lane_wr = {cpu_we && hit.dat_hi, cpu_we && hit.dat_lo};
  assign lane_rd = {rd_go && hit.dat_hi, rd_go && hit.dat_lo};

  vram_addr_gen i_addr_gen (
    .clk        (clk),
    .rst        (rst),
    .ld_lo      (cpu_we && hit.adr_lo),
    .ld_hi      (cpu_we && hit.adr_hi),
    .ld_byte    (cpu_wdata),
    .acc_lo     (lane_wr[0] || lane_rd[0]),
    .acc_hi     (lane_wr[1] || lane_rd[1]),
    .trig_on_hi (ctrl_q[CTRL_TRIG_BIT]),
    .step_sel   (ctrl_q[1:0]),
    .word_addr  (word_addr)
  );

  assign mem_idx = word_addr[WORD_AW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vram_byte_bank #(.AW(WORD_AW), .DW(BYTE_W)) i_bank (
      .clk   (clk),
      .wr_en (lane_wr[g]),
      .rd_en (lane_rd[g]),
      .idx   (mem_idx),
      .wdata (cpu_wdata),
      .rdata (lane_q[g])
    );
  end

  // control and return registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ret_lo_q <= '0;
      ret_hi_q <= '0;
    end else if (cpu_we) begin
      if (hit.ctrl)   ctrl_q   <= cpu_wdata;
      if (hit.dat_lo) ret_lo_q <= cpu_wdata;
      if (hit.dat_hi) ret_hi_q <= cpu_wdata;
    end
  end

  // read source selection
  always_comb begin
    rsrc_d  = RSRC_REG;
    reg_val = 8'h00;
    if (!in_win)         reg_val = 8'hFF;
    else if (hit.ctrl)   reg_val = ctrl_q;
    else if (hit.adr_lo) reg_val = word_addr[BYTE_W-1:0];
    else if (hit.adr_hi) reg_val = word_addr[WADDR_W-1:BYTE_W];
    else if (hit.ret_lo) reg_val = ret_lo_q;
    else if (hit.ret_hi) reg_val = ret_hi_q;
    else if (hit.dat_lo) rsrc_d  = RSRC_MEM_LO;
    else if (hit.dat_hi) rsrc_d  = RSRC_MEM_HI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rsrc_q   <= RSRC_REG;
    end else if (rd_go) begin
      reg_rd_q <= reg_val;
      rsrc_q   <= rsrc_d;
    end
  end

  always_comb begin
    case (rsrc_q)
      RSRC_MEM_LO: cpu_rdata = lane_q[0];
      RSRC_MEM_HI: cpu_rdata = lane_q[1];
      default:     cpu_rdata = reg_rd_q;
    endcase
  end

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
  import vram_port_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h0400
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic        cpu_re,
  input logic [7:0]  cpu_rdata,
  input logic [15:0] word_addr,
  input logic [7:0]  ctrl,
  input logic [7:0]  ret_lo,
  input logic [7:0]  ret_hi
);

  logic inw, a_dlo, a_dhi, a_rlo, trig_lo, trig_hi;
  logic [15:0] stp;

  assign inw     = (cpu_addr[15:6] == WIN_BASE[15:6]);
  assign a_dlo   = inw && (cpu_addr[5:0] == OFS_DAT_LO);
  assign a_dhi   = inw && (cpu_addr[5:0] == OFS_DAT_HI);
  assign a_rlo   = inw && (cpu_addr[5:0] == OFS_RET_LO);
  assign trig_lo = !ctrl[CTRL_TRIG_BIT];
  assign trig_hi = ctrl[CTRL_TRIG_BIT];
  assign stp     = step_amount(ctrl[1:0]);

  p_oob_read_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && !cpu_we && !inw) |=> (cpu_rdata == 8'hFF));

  p_oob_write_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && !inw) |=> ($stable(ctrl) && $stable(word_addr)));

  p_write_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && ((a_dlo && trig_lo) || (a_dhi && trig_hi)))
    |=> (word_addr == $past(word_addr) + $past(stp)));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && ((a_dlo && trig_hi) || (a_dhi && trig_lo))) |=> $stable(word_addr));

  p_read_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && !cpu_we && ((a_dlo && trig_lo) || (a_dhi && trig_hi)))
    |=> (word_addr == $past(word_addr) + $past(stp)));

  p_ret_copy_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && a_dhi) |=> (ret_hi == $past(cpu_wdata)));

  p_ret_ro_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && a_rlo) |=> $stable(ret_lo));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (word_addr == 16'h0 && ctrl == 8'h0 && ret_lo == 8'h0 && ret_hi == 8'h0));

endmodule

bind vram_port vram_port_chk #(.WIN_BASE(WIN_BASE)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_we    (cpu_we),
  .cpu_re    (cpu_re),
  .cpu_rdata (cpu_rdata),
  .word_addr (word_addr),
  .ctrl      (ctrl_q),
  .ret_lo    (ret_lo_q),
  .ret_hi    (ret_hi_q)
);

// File: tb/test_vram_port.sv
module test_vram_port;

  localparam logic [15:0] BASE = 16'h0400;
  localparam logic [15:0] A_CTRL = BASE + 16'h00;
  localparam logic [15:0] A_ALO  = BASE + 16'h01;
  localparam logic [15:0] A_AHI  = BASE + 16'h02;
  localparam logic [15:0] A_DLO  = BASE + 16'h03;
  localparam logic [15:0] A_DHI  = BASE + 16'h04;
  localparam logic [15:0] A_RLO  = BASE + 16'h08;
  localparam logic [15:0] A_RHI  = BASE + 16'h09;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_re = 1'b0;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       re_seen = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vram_port #(.WIN_BASE(BASE), .WORD_AW(11)) i_vram_port (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata)
  );

  // monitor: read data is due one clock after the strobe
  always @(posedge clk) re_seen <= cpu_re && !cpu_we && !rst;

  always @(negedge clk) begin
    if (re_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read result actual=%02h expected=none", cpu_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (cpu_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", t, cpu_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_re = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0; cpu_re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_we = 1'b0; cpu_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] w);
    wr(A_AHI, w[15:8]);
    wr(A_ALO, w[7:0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset values
    rd(A_CTRL, 8'h00, "R9 ctrl after reset");
    rd(A_ALO,  8'h00, "R9 addr lo after reset");
    rd(A_AHI,  8'h00, "R9 addr hi after reset");
    rd(A_RLO,  8'h00, "R9 ret lo after reset");
    rd(A_RHI,  8'h00, "R9 ret hi after reset");

    // R1 independent address bytes, any order
    wr(A_AHI, 8'h12); wr(A_ALO, 8'h34);
    rd(A_ALO, 8'h34, "R1 addr lo"); rd(A_AHI, 8'h12, "R1 addr hi");
    wr(A_ALO, 8'h78);
    rd(A_AHI, 8'h12, "R1 hi kept"); rd(A_ALO, 8'h78, "R1 lo alone");

    // R3 trigger on low byte, R7 copy into return registers
    wr(A_CTRL, 8'h00); wr(A_ALO, 8'h34);
    wr(A_DHI, 8'hAB);
    rd(A_ALO, 8'h34, "R3 high write no step");
    wr(A_DLO, 8'hCD);
    rd(A_ALO, 8'h35, "R3 low write steps"); rd(A_AHI, 8'h12, "R3 hi unchanged");
    rd(A_RLO, 8'hCD, "R7 ret lo copy"); rd(A_RHI, 8'hAB, "R7 ret hi copy");
    wr(A_RLO, 8'h55); wr(A_RHI, 8'h66);
    rd(A_RLO, 8'hCD, "R7 ret lo read-only"); rd(A_RHI, 8'hAB, "R7 ret hi read-only");

    // R5 alias through masked index, R4 read stepping on high byte
    set_addr(16'h0234); wr(A_CTRL, 8'h80);
    rd(A_DLO, 8'hCD, "R5 low lane readback");
    rd(A_ALO, 8'h34, "R4 low read no step when bit7=1");
    rd(A_DHI, 8'hAB, "R5 high lane readback");
    rd(A_ALO, 8'h35, "R4 high read steps");

    // R2 step sizes
    wr(A_CTRL, 8'h81); set_addr(16'h0000); wr(A_DHI, 8'h11);
    rd(A_ALO, 8'h20, "R2 step 32"); rd(A_AHI, 8'h00, "R2 step 32 hi");
    wr(A_CTRL, 8'h82); wr(A_ALO, 8'h00); wr(A_DHI, 8'h11);
    rd(A_ALO, 8'h80, "R2 step 128 sel 10");
    wr(A_CTRL, 8'h83); wr(A_ALO, 8'h00); wr(A_DHI, 8'h11);
    rd(A_ALO, 8'h80, "R2 step 128 sel 11");
    wr(A_CTRL, 8'h02); wr(A_ALO, 8'h00); wr(A_DLO, 8'h11);
    rd(A_ALO, 8'h80, "R2 step 128 on low trigger");

    // R5 sequential fill and readback
    wr(A_CTRL, 8'h00); set_addr(16'h0100);
    for (int i = 0; i < 4; i++) begin
      wr(A_DHI, 8'h40 + 8'(i)); wr(A_DLO, 8'hC0 + 8'(i));
    end
    set_addr(16'h0100);
    for (int i = 0; i < 4; i++) begin
      rd(A_DHI, 8'h40 + 8'(i), "R5 fill hi");
      rd(A_DLO, 8'hC0 + 8'(i), "R5 fill lo");
    end
    rd(A_ALO, 8'h04, "R5 address after walk");

    // R10 back-to-back: step visible on next cycle
    set_addr(16'h0100);
    rd(A_DLO, 8'hC0, "R10 data read");
    rd(A_ALO, 8'h01, "R10 step seen next cycle");

    // R8 wrap
    wr(A_CTRL, 8'h01); set_addr(16'hFFF0); wr(A_DLO, 8'h5A);
    rd(A_ALO, 8'h10, "R8 wrap by 32 lo"); rd(A_AHI, 8'h00, "R8 wrap by 32 hi");
    wr(A_CTRL, 8'h00); set_addr(16'hFFFF); wr(A_DLO, 8'h77);
    rd(A_ALO, 8'h00, "R8 wrap by 1 lo"); rd(A_AHI, 8'h00, "R8 wrap by 1 hi");

    // R6 outside the window
    rd(16'h0000, 8'hFF, "R6 read below window");
    rd(BASE - 16'h1, 8'hFF, "R6 read just below window");
    rd(BASE + 16'h40, 8'hFF, "R6 read just past window");
    wr(16'h0800, 8'h83); wr(16'h0801, 8'h99);
    rd(A_CTRL, 8'h00, "R6 outside write ignored ctrl");
    rd(A_ALO, 8'h00, "R6 outside write ignored addr");

    // R11 unassigned offsets
    wr(BASE + 16'h20, 8'h99);
    rd(BASE + 16'h20, 8'h00, "R11 unused offset reads zero");
    rd(BASE + 16'h3F, 8'h00, "R11 last offset reads zero");
    rd(A_CTRL, 8'h00, "R11 unused write no effect");
    idle();

    // R9 memory kept across reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(A_ALO, 8'h00, "R9 addr cleared again");
    set_addr(16'h0101);
    rd(A_DHI, 8'h41, "R9 memory kept across reset");
    idle();

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule